// File: doc/BRIEF.md
# Programmable Serial Shift-Clock Generator

This block makes the shift timing for one serial channel. An upstream prescaler supplies a single-cycle count-source enable. An 8-bit reload counter divides that rate by (divide value + 1). A post-divider then sets the final rate: it divides by 2 when the channel runs as a clocked synchronous link on its internal clock, and by 16 when the channel runs as a UART. The result is a single-cycle shift enable for the transmit and receive shifters, plus a divided clock-out level.

Software loads the divide value through a one-word write port. The divide register has no reset value, so it must be written before the generator is enabled. A write made while the counter is running does not disturb the count in progress. The counter picks up the new value only when it reloads at the end of that count. When the synchronous link takes its clock from outside, the counter and post-divider are bypassed and the shift enable follows an external, already synchronized tick.

Top module: `baud_gen`

## Requirements
- R1: After a synchronous active-low reset, with `en` low, `shift_tick` and `clk_out` are both 0.
- R2: In internally clocked synchronous mode (`mode_uart`=0, `ext_clk_sel`=0) with divide value D, `shift_tick` pulses for one cycle once every 2·(D+1) `src_tick` pulses.
- R3: In UART mode (`mode_uart`=1) with divide value D, `shift_tick` pulses for one cycle once every 16·(D+1) `src_tick` pulses. `ext_clk_sel` is ignored in this mode.
- R4: In both internal modes, `clk_out` toggles once at each terminal count, so it is the counter output divided by 2. It starts low after enable. In synchronous mode, `shift_tick` coincides with the falling edge of `clk_out`.
- R5: A write to the divide value while counting leaves the current count unchanged. The new value sets the length of the next count, starting at the reload.
- R6: In externally clocked synchronous mode (`mode_uart`=0, `ext_clk_sel`=1), `shift_tick` equals `ext_shift` delayed by one clock, `clk_out` stays 0, and `src_tick` has no effect.
- R7: `mode_uart` and `ext_clk_sel` are captured only on clock edges where `en` is 0. Changing them while enabled has no effect on the outputs.
- R8: While `en` is 0, the outputs are 0 and the counter is held at the divide value. The first terminal count after enable therefore comes on the (D+1)th `src_tick`.
- R9: A divide value of 0 gives a terminal count on every `src_tick`.
- R10: The counter advances only on cycles where `src_tick` is 1. Gaps in `src_tick` stretch the output periods accordingly.
- R11: The outputs are registered. They change on the clock edge at which the terminal `src_tick` (or `ext_shift`) is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Generator enable; low holds everything cleared |
| mode_uart | input | 1 | 1 = UART (/16), 0 = synchronous link (/2) |
| ext_clk_sel | input | 1 | Synchronous link only: 1 = external shift clock |
| src_tick | input | 1 | Count-source enable from the prescaler |
| ext_shift | input | 1 | Synchronized external shift tick |
| wr_en | input | 1 | Divide-value write strobe |
| wr_data | input | 8 | Divide value to write |
| shift_tick | output | 1 | Single-cycle shift enable |
| clk_out | output | 1 | Counter output divided by 2 |

## Verification
The hardest case to reach is a divide-value write that lands in the middle of a count, because from the ports the reload instant is visible only indirectly, through the output timing. The stimulus loads a large value, enables the generator, and rewrites the value a few `src_tick` pulses later. The reference model then shows that the long count runs to its end before the shorter period starts. Irregular `src_tick` gaps from a bench LFSR, and mode inputs changed while enabled, push the same comparison into the stretched-period and ignored-input cases.

// File: rtl/baud_pkg.sv
// Shared types for the shift-clock generator.
// Assumes: one serial channel per generator instance.
package baud_pkg;
    typedef enum logic {
        MODE_SYNC = 1'b0,
        MODE_UART = 1'b1
    } baud_mode_e;
endpackage

// File: rtl/baud_reload_cnt.sv
// Down-counting reload counter. Counts src_tick pulses from the loaded
// divide value to zero, then reloads and raises term for that cycle.
// Assumes: div_val is read only at reload or while held (run low).
module baud_reload_cnt #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             src_tick,
    input  logic [DIV_W-1:0] div_val,
    output logic             term
);
    logic [DIV_W-1:0] cnt;

    // terminal count: zero reached on a count-source enable
    assign term = run && src_tick && (cnt == '0);

    // counter: held at divide value when idle, reload at zero, else decrement
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run)         cnt <= div_val;
        else if (src_tick) begin
            if (cnt == '0)     cnt <= div_val;
            else               cnt <= cnt - 1'b1;
        end
    end

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !src_tick) |=> $stable(cnt));
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && src_tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && src_tick && cnt == '0) |=> (cnt == $past(div_val)));
endmodule

// File: rtl/baud_post_div.sv
// Mode post-divider. Counts terminal pulses modulo SYNC_POST or UART_POST,
// emits a registered one-cycle shift enable per full period, and toggles
// a clock-out level on every terminal pulse.
// Assumes: uart is stable whenever run is high.
module baud_post_div #(
    parameter int SYNC_POST = 2,
    parameter int UART_POST = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic uart,
    input  logic term,
    output logic shift_q,
    output logic clk_q
);
    localparam int MAXP = (UART_POST > SYNC_POST) ? UART_POST : SYNC_POST;
    localparam int PW   = (MAXP > 2) ? $clog2(MAXP) : 1;
    localparam logic [PW-1:0] U_LAST = PW'(UART_POST - 1);
    localparam logic [PW-1:0] S_LAST = PW'(SYNC_POST - 1);

    logic [PW-1:0] pcnt;
    logic          at_last;

    // last phase of the selected post-divide period
    assign at_last = (pcnt == (uart ? U_LAST : S_LAST));

    // phase counter, shift enable and clock-out level
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pcnt    <= '0;
            shift_q <= 1'b0;
            clk_q   <= 1'b0;
        end else begin
            shift_q <= term && at_last;
            if (term) begin
                pcnt  <= at_last ? '0 : pcnt + 1'b1;
                clk_q <= ~clk_q;
            end
        end
    end

    // R8
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pcnt == '0 && !clk_q && !shift_q));
    // R4
    toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && term) |=> (clk_q != $past(clk_q)));
    // R4
    sync_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !uart && shift_q) |-> !clk_q);
endmodule

// File: rtl/baud_gen.sv
// Shift-clock generator top. Holds the divide register (no reset: it must
// be written before enabling), captures mode and clock source while
// disabled, and selects the internal divider chain or the external tick.
// Assumes: ext_shift is already synchronized to clk.
module baud_gen #(
    parameter int DIV_W     = 8,
    parameter int SYNC_POST = 2,
    parameter int UART_POST = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             mode_uart,
    input  logic             ext_clk_sel,
    input  logic             src_tick,
    input  logic             ext_shift,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_data,
    output logic             shift_tick,
    output logic             clk_out
);
    import baud_pkg::*;

    logic [DIV_W-1:0] div_reg;
    baud_mode_e       mode_q;
    logic             xsel_q;
    logic             int_run, ext_run, term, int_shift, ext_tick_q;

    // divide register: software write, takes effect at the next reload
    always_ff @(posedge clk) begin
        if (wr_en) div_reg <= wr_data;
    end

    // mode and clock source captured only while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_SYNC;
            xsel_q <= 1'b0;
        end else if (!en) begin
            mode_q <= mode_uart ? MODE_UART : MODE_SYNC;
            xsel_q <= ext_clk_sel;
        end
    end

    // path select: external bypass only in synchronous mode
    assign ext_run = en && (mode_q == MODE_SYNC) && xsel_q;
    assign int_run = en && !ext_run;

    baud_reload_cnt #(.DIV_W(DIV_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(int_run), .src_tick(src_tick),
        .div_val(div_reg), .term(term)
    );

    baud_post_div #(.SYNC_POST(SYNC_POST), .UART_POST(UART_POST)) u_post (
        .clk(clk), .rst_n(rst_n), .run(int_run), .uart(mode_q == MODE_UART),
        .term(term), .shift_q(int_shift), .clk_q(clk_out)
    );

    // external tick register, one clock of latency like the internal path
    always_ff @(posedge clk) begin
        if (!rst_n) ext_tick_q <= 1'b0;
        else        ext_tick_q <= ext_run && ext_shift;
    end

    assign shift_tick = int_shift || ext_tick_q;

    // R6
    ext_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_run |-> !clk_out);
    // R7
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && en) |-> ($stable(mode_q) && $stable(xsel_q)));
    // R1
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!shift_tick && !clk_out));
endmodule

// File: tb/baud_gen_tb.sv
module baud_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, mode_uart = 1'b0, ext_clk_sel = 1'b0;
    logic src_tick = 1'b0, ext_shift = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic shift_tick, clk_out;

    int checks = 0, fails = 0, cycles = 0;
    int src_pat = 0;          // 0 none, 1 every cycle, 2 irregular
    logic [15:0] lfsr = 16'hACE1;
    string cur_req = "R1";

    // reference model state
    int m_div = 0, m_cnt = 0, m_p = 0;
    bit m_clk = 0, m_sh = 0, m_mode = 0, m_xs = 0;

    baud_gen u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_uart(mode_uart),
        .ext_clk_sel(ext_clk_sel), .src_tick(src_tick), .ext_shift(ext_shift),
        .wr_en(wr_en), .wr_data(wr_data), .shift_tick(shift_tick), .clk_out(clk_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference, evaluated on pre-edge inputs
    always @(posedge clk) begin
        int nd;
        nd = wr_en ? int'(wr_data) : m_div;
        if (!rst_n) begin
            m_cnt = 0; m_p = 0; m_clk = 0; m_sh = 0; m_mode = 0; m_xs = 0;
        end else if (!en) begin
            m_mode = mode_uart; m_xs = ext_clk_sel;
            m_cnt = m_div; m_p = 0; m_clk = 0; m_sh = 0;
        end else if (!m_mode && m_xs) begin
            m_sh = ext_shift; m_cnt = m_div; m_p = 0; m_clk = 0;
        end else begin
            m_sh = 0;
            if (src_tick) begin
                if (m_cnt == 0) begin
                    m_cnt = m_div;
                    m_clk = !m_clk;
                    if (m_p == (m_mode ? 15 : 1)) begin m_sh = 1; m_p = 0; end
                    else m_p++;
                end else m_cnt--;
            end
        end
        m_div = nd;
    end

    // stimulus pattern for the count source and external tick; cycle compare
    always @(negedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <%0d cycles", cycles, WATCHDOG);
            finish_run();
        end
        if (rst_n) begin
            check(cur_req, "shift_tick", int'(shift_tick), int'(m_sh));
            check(cur_req, "clk_out", int'(clk_out), int'(m_clk));
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        src_tick  = (src_pat == 1) || (src_pat == 2 && lfsr[0]);
        ext_shift = lfsr[3] & lfsr[7];
    end

    task automatic write_div(int v);
        @(negedge clk); wr_en = 1'b1; wr_data = 8'(v);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // measure cycles between two consecutive shift ticks
    task automatic measure(string req, int exp);
        int n = 0;
        for (int i = 0; i < 2000 && !shift_tick; i++) @(negedge clk);
        @(negedge clk);
        while (!shift_tick && n < 2000) begin n++; @(negedge clk); end
        check(req, "shift period", n + 1, exp);
    endtask

    task automatic restart(bit uart, bit xs, int d, int pat);
        @(negedge clk); en = 1'b0; mode_uart = uart; ext_clk_sel = xs;
        write_div(d);
        src_pat = pat;
        wait_cycles(2);
        en = 1'b1;
    endtask

    initial begin
        wait_cycles(3);
        cur_req = "R1";
        check("R1", "shift_tick in reset", int'(shift_tick), 0);
        check("R1", "clk_out in reset", int'(clk_out), 0);
        rst_n = 1'b1;
        wait_cycles(4);
        check("R1", "shift_tick idle", int'(shift_tick), 0);

        cur_req = "R2"; restart(1'b0, 1'b0, 3, 1);
        measure("R2", 8); wait_cycles(20);

        cur_req = "R3"; restart(1'b1, 1'b1, 1, 1);
        measure("R3", 32); wait_cycles(40);

        cur_req = "R9"; restart(1'b0, 1'b0, 0, 1);
        measure("R9", 2); wait_cycles(10);

        cur_req = "R4"; restart(1'b1, 1'b0, 2, 1);
        wait_cycles(60);

        cur_req = "R10"; restart(1'b0, 1'b0, 2, 2);
        wait_cycles(200);

        cur_req = "R5"; restart(1'b0, 1'b0, 9, 1);
        wait_cycles(3); write_div(2);
        wait_cycles(60);
        cur_req = "R5"; restart(1'b1, 1'b0, 1, 1);
        wait_cycles(5); write_div(4);
        wait_cycles(200);

        cur_req = "R7"; restart(1'b0, 1'b0, 1, 1);
        wait_cycles(5); mode_uart = 1'b1; ext_clk_sel = 1'b1;
        measure("R7", 4); wait_cycles(30);

        cur_req = "R6"; restart(1'b0, 1'b1, 5, 2);
        wait_cycles(150);

        cur_req = "R8"; restart(1'b0, 1'b0, 4, 1);
        wait_cycles(7); en = 1'b0;
        wait_cycles(3);
        check("R8", "clk_out disabled", int'(clk_out), 0);
        en = 1'b1;
        wait_cycles(40);

        cur_req = "R11"; restart(1'b1, 1'b0, 0, 2);
        wait_cycles(300);

        en = 1'b0; src_pat = 0;
        wait_cycles(3);
        finish_run();
    end
endmodule